// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a 64-bit virtual address into a real address by reading translation tables from memory. A control element, picked by the address-space mode of the request, gives the first table's origin and type. The type decides how many levels the walk has: it starts at region-first, region-second, region-third or segment level, and it always ends at the page level. The block reads one 64-bit table entry at a time over a read-only memory port. At each level it checks the entry, and it carries the next table origin forward until it reaches the page entry.

The caller sends a virtual address, a write flag and a mode, then waits for one response. A response carries either a real address with a write-permitted flag, or a fault type with a translation-exception code. When translation is switched off, the address is passed through. In both cases a resulting address below the low-core limit is moved by the prefix base before it is returned.

Top module: `ptw_walker`

## Requirements
- R1: `req_mode` picks the control element: 00 and 01 take `ctl_primary`, 10 takes `ctl_secondary`, 11 takes `ctl_home`. The address-space bits used in exception codes are 0 for modes 00 and 01, 2 for mode 10 and 3 for mode 11.
- R2: With `xlate_en` low, a request returns its virtual address as the real address (after R10), with `rsp_wr_ok`=1, fault type 0 and no memory reads.
- R3: The control element's type field in bits [3:2] (11 region-first, 10 region-second, 01 region-third, 00 segment) sets the first level. Before any read, the address must fit that type: for region-second any of bits 63..53 set, for region-third any of 63..42, and for segment any of 63..31, gives fault type 1 (specification). Region-first has no such check.
- R4: Each read address is the table origin (the entry or control element with bits [11:0] cleared) plus a byte offset: region-first table (va>>50)&0x3FF8, region-second (va>>39)&0x3FF8, region-third (va>>28)&0x3FF8, segment (va>>17)&0x3FF8, page (va>>9)&0x7F8.
- R5: A region or segment entry with bit 5 set gives fault type 2 (segment translation). A page entry with bit 10 set gives fault type 3 (page translation).
- R6: A valid region entry must carry, in bits [3:2], the type of the table it points to: 10 from region-first, 01 from region-second, 00 from region-third. Any other value gives fault type 1. Segment entries are not type-checked.
- R7: A valid page entry yields the real address {entry[63:12], va[11:0]}, with `rsp_wr_ok` equal to the inverse of the entry's read-only bit 9.
- R8: A write request that reaches a read-only page entry gives fault type 4 (protection) instead of an address, and `rsp_wr_ok` is 0 on every fault.
- R9: On a fault, `rsp_exc_code` is the virtual address with bits [11:0] cleared, ORed with the R1 address-space bits, plus 4 for a protection fault.
- R10: A real address below 0x2000, whether translated or passed through, has `prefix_base` added. An address of 0x2000 or above is unchanged.
- R11: There is at most one outstanding read. `mem_req` and `mem_rd_addr` stay stable until `mem_rsp_valid`. `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xlate_en | input | 1 | Address translation enabled |
| ctl_primary | input | 64 | Control element for primary mode |
| ctl_secondary | input | 64 | Control element for secondary mode |
| ctl_home | input | 64 | Control element for home mode |
| prefix_base | input | 64 | Offset added to real addresses below 0x2000 |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_mode | input | 2 | Address-space mode |
| mem_req | output | 1 | Table entry read pending |
| mem_rd_addr | output | 64 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_raddr | output | 64 | Real address |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_fault_type | output | 3 | 0 none, 1 specification, 2 segment translation, 3 page translation, 4 protection |
| rsp_exc_code | output | 64 | Translation-exception code |

## Verification
Two things are settled in the same cycle as the page-entry response: the write-permission decision and the prefix move of a low frame. The bench builds a page entry that is read-only and points to frame 0x1000, then sends a write. The protection fault must win, with the exception code carrying the protection flag and the address-space bits, and no relocated address may leak through. The same tables are also used for a read, which must return the prefix-moved address with write permission cleared, and for a frame at exactly 0x2000, which must come back unmoved.

// File: rtl/ptw_pkg.sv
// Shared types and field positions for the page table walker.
// Assumes 64-bit virtual addresses and 8-byte table entries.
package ptw_pkg;
    localparam int VA_W        = 64;
    localparam int ENT_INV_BIT = 5;
    localparam int PTE_RO_BIT  = 9;
    localparam int PTE_INV_BIT = 10;
    // lowest address bit that must be zero for a table type to fit
    localparam int FIT_R2_LSB  = 53;
    localparam int FIT_R3_LSB  = 42;
    localparam int FIT_SEG_LSB = 31;
    // lowest virtual-address bit of each table index and index widths
    localparam int IDX_R1_LSB  = 53;
    localparam int IDX_R2_LSB  = 42;
    localparam int IDX_R3_LSB  = 31;
    localparam int IDX_SEG_LSB = 20;
    localparam int IDX_PG_LSB  = 12;
    localparam int IDX_W       = 11;
    localparam int IDX_PG_W    = 8;

    typedef enum logic [2:0] {
        LV_R1 = 3'd0, LV_R2 = 3'd1, LV_R3 = 3'd2, LV_SEG = 3'd3, LV_PAGE = 3'd4
    } lvl_e;

    typedef enum logic [2:0] {
        FT_NONE = 3'd0, FT_SPEC = 3'd1, FT_SEGX = 3'd2, FT_PAGEX = 3'd3, FT_PROT = 3'd4
    } flt_e;

    // Level at which a walk starts for a control-element type code
    function automatic lvl_e start_level(input logic [1:0] tcode);
        case (tcode)
            2'b11:   return LV_R1;
            2'b10:   return LV_R2;
            2'b01:   return LV_R3;
            default: return LV_SEG;
        endcase
    endfunction
endpackage

// File: rtl/ptw_ce_select.sv
// Picks the control element and the address-space bits from the mode.
// Assumes mode 01 behaves as primary with address-space bits 0.
module ptw_ce_select import ptw_pkg::*; (
    input  logic [1:0]      mode,
    input  logic [VA_W-1:0] ctl_primary,
    input  logic [VA_W-1:0] ctl_secondary,
    input  logic [VA_W-1:0] ctl_home,
    output logic [VA_W-1:0] ce,
    output logic [1:0]      as_bits
);
    // mode decode into element and address-space bits
    always_comb begin
        case (mode)
            2'b10:   begin ce = ctl_secondary; as_bits = 2'b10; end
            2'b11:   begin ce = ctl_home;      as_bits = 2'b11; end
            default: begin ce = ctl_primary;   as_bits = 2'b00; end
        endcase
    end
endmodule

// File: rtl/ptw_range_check.sv
// Flags a virtual address too wide for the starting table type.
// Assumes the caller passes only the address bits at and above FIT_SEG_LSB.
module ptw_range_check import ptw_pkg::*; (
    input  logic [1:0]                  tcode,
    input  logic [VA_W-1:FIT_SEG_LSB]   va_hi,
    output logic                        no_fit
);
    // any set bit above the span of the starting table is a fault
    always_comb begin
        case (tcode)
            2'b10:   no_fit = |va_hi[VA_W-1:FIT_R2_LSB];
            2'b01:   no_fit = |va_hi[VA_W-1:FIT_R3_LSB];
            2'b00:   no_fit = |va_hi[VA_W-1:FIT_SEG_LSB];
            default: no_fit = 1'b0;
        endcase
    end
endmodule

// File: rtl/ptw_index.sv
// Forms the byte offset of the entry inside the table of a given level.
// Assumes 8-byte entries, so each index is shifted left by three.
module ptw_index import ptw_pkg::*; (
    input  lvl_e            level,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] offset
);
    logic unused_lo;
    assign unused_lo = ^vaddr[IDX_PG_LSB-1:0];

    // select the index field of the level and scale it to bytes
    always_comb begin
        offset = '0;
        case (level)
            LV_R1:   offset[IDX_W+2:3]    = vaddr[IDX_R1_LSB+:IDX_W];
            LV_R2:   offset[IDX_W+2:3]    = vaddr[IDX_R2_LSB+:IDX_W];
            LV_R3:   offset[IDX_W+2:3]    = vaddr[IDX_R3_LSB+:IDX_W];
            LV_SEG:  offset[IDX_W+2:3]    = vaddr[IDX_SEG_LSB+:IDX_W];
            default: offset[IDX_PG_W+2:3] = vaddr[IDX_PG_LSB+:IDX_PG_W];
        endcase
    end
endmodule

// File: rtl/ptw_entry_check.sv
// Judges one fetched entry against the level it was read from.
// Assumes invalid has priority over a type mismatch.
module ptw_entry_check import ptw_pkg::*; (
    input  lvl_e       level,
    input  logic [1:0] tcode,
    input  logic       inv,
    input  logic       pinv,
    output flt_e       fault
);
    logic [1:0] want;

    // type code that a region entry must carry for its target table
    always_comb begin
        case (level)
            LV_R1:   want = 2'b10;
            LV_R2:   want = 2'b01;
            default: want = 2'b00;
        endcase
    end

    // fault decision for the entry
    always_comb begin
        fault = FT_NONE;
        if (level == LV_PAGE) begin
            if (pinv) fault = FT_PAGEX;
        end else if (inv) begin
            fault = FT_SEGX;
        end else if (level != LV_SEG && tcode != want) begin
            fault = FT_SPEC;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
// Top of the page table walker: accepts a request, walks the tables one
// read at a time, and returns a prefixed real address or a fault.
// Assumes the memory port holds data valid for exactly one cycle per read.
module ptw_walker import ptw_pkg::*; #(
    parameter int          PAGE_BITS = 12,
    parameter logic [63:0] LOW_LIMIT = 64'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xlate_en,
    input  logic [63:0] ctl_primary,
    input  logic [63:0] ctl_secondary,
    input  logic [63:0] ctl_home,
    input  logic [63:0] prefix_base,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_vaddr,
    input  logic        req_write,
    input  logic [1:0]  req_mode,
    output logic        mem_req,
    output logic [63:0] mem_rd_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        rsp_valid,
    output logic [63:0] rsp_raddr,
    output logic        rsp_wr_ok,
    output logic [2:0]  rsp_fault_type,
    output logic [63:0] rsp_exc_code
);
    localparam logic [VA_W-1:0] PAGE_MASK = ~((64'd1 << PAGE_BITS) - 64'd1);
    localparam logic [VA_W-1:0] PROT_FLAG = 64'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} st_e;

    st_e             state;
    logic [VA_W-1:0] va_q, origin_q, raddr_q, exc_q;
    logic            wr_q, wrok_q;
    logic [1:0]      as_q;
    lvl_e            lvl_q;
    flt_e            ft_q;

    logic [VA_W-1:0] sel_ce, idx_off, page_addr;
    logic [1:0]      sel_as;
    logic            no_fit, ent_ro;
    flt_e            ent_fault;

    logic unused_bits;
    assign unused_bits = ^{sel_ce[11:4], sel_ce[1:0], mem_rsp_data[11],
                           mem_rsp_data[8:6], mem_rsp_data[4], mem_rsp_data[1:0]};

    ptw_ce_select u_sel (
        .mode(req_mode), .ctl_primary(ctl_primary), .ctl_secondary(ctl_secondary),
        .ctl_home(ctl_home), .ce(sel_ce), .as_bits(sel_as)
    );

    ptw_range_check u_fit (
        .tcode(sel_ce[3:2]), .va_hi(req_vaddr[VA_W-1:FIT_SEG_LSB]), .no_fit(no_fit)
    );

    ptw_index u_idx (.level(lvl_q), .vaddr(va_q), .offset(idx_off));

    ptw_entry_check u_ent (
        .level(lvl_q), .tcode(mem_rsp_data[3:2]), .inv(mem_rsp_data[ENT_INV_BIT]),
        .pinv(mem_rsp_data[PTE_INV_BIT]), .fault(ent_fault)
    );

    // low-core relocation of a real address
    function automatic logic [VA_W-1:0] to_abs(input logic [VA_W-1:0] a,
                                               input logic [VA_W-1:0] pfx);
        return (a < LOW_LIMIT) ? a + pfx : a;
    endfunction

    // exception code: page-aligned address, space bits, protection flag
    function automatic logic [VA_W-1:0] exc_code(input logic [VA_W-1:0] va,
                                                 input logic [1:0] asb, input logic prot);
        return (va & PAGE_MASK) | {{(VA_W-2){1'b0}}, asb} | (prot ? PROT_FLAG : '0);
    endfunction

    // frame from the page entry joined with the page offset
    assign ent_ro    = mem_rsp_data[PTE_RO_BIT];
    assign page_addr = (mem_rsp_data & PAGE_MASK) | (va_q & ~PAGE_MASK);

    assign req_ready      = (state == ST_IDLE);
    assign mem_req        = (state == ST_FETCH);
    assign mem_rd_addr    = origin_q + idx_off;
    assign rsp_valid      = (state == ST_DONE);
    assign rsp_raddr      = raddr_q;
    assign rsp_wr_ok      = wrok_q;
    assign rsp_fault_type = ft_q;
    assign rsp_exc_code   = exc_q;

    // walk sequencer: accept, fetch level by level, report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            va_q     <= '0;
            origin_q <= '0;
            raddr_q  <= '0;
            exc_q    <= '0;
            wr_q     <= 1'b0;
            wrok_q   <= 1'b0;
            as_q     <= 2'b00;
            lvl_q    <= LV_R1;
            ft_q     <= FT_NONE;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    wr_q    <= req_write;
                    as_q    <= sel_as;
                    ft_q    <= FT_NONE;
                    wrok_q  <= 1'b0;
                    raddr_q <= '0;
                    exc_q   <= '0;
                    if (!xlate_en) begin
                        raddr_q <= to_abs(req_vaddr, prefix_base);
                        wrok_q  <= 1'b1;
                        state   <= ST_DONE;
                    end else if (no_fit) begin
                        ft_q  <= FT_SPEC;
                        exc_q <= exc_code(req_vaddr, sel_as, 1'b0);
                        state <= ST_DONE;
                    end else begin
                        lvl_q    <= start_level(sel_ce[3:2]);
                        origin_q <= sel_ce & PAGE_MASK;
                        state    <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_rsp_valid) begin
                    if (ent_fault != FT_NONE) begin
                        ft_q  <= ent_fault;
                        exc_q <= exc_code(va_q, as_q, 1'b0);
                        state <= ST_DONE;
                    end else if (lvl_q == LV_PAGE) begin
                        if (wr_q && ent_ro) begin
                            ft_q  <= FT_PROT;
                            exc_q <= exc_code(va_q, as_q, 1'b1);
                        end else begin
                            raddr_q <= to_abs(page_addr, prefix_base);
                            wrok_q  <= !ent_ro;
                        end
                        state <= ST_DONE;
                    end else begin
                        origin_q <= mem_rsp_data & PAGE_MASK;
                        lvl_q    <= lvl_e'(lvl_q + 3'd1);
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol and result checks for the page table walker, bound to its top.
// Assumes the signals are those of the walker's own ports.
module ptw_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req,
    input logic [63:0] mem_rd_addr,
    input logic        mem_rsp_valid,
    input logic        rsp_valid,
    input logic        rsp_wr_ok,
    input logic [2:0]  rsp_fault_type,
    input logic [11:2] exc_low
);
    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || rsp_valid) |-> !req_ready);

    assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_rd_addr)));

    assert_rsp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_entry_align_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_rd_addr[2:0] == 3'b000));

    assert_fault_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_type != 3'd0) |-> !rsp_wr_ok);

    assert_prot_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_type == 3'd4) |-> exc_low[2]);

    assert_code_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_type != 3'd0) |-> (exc_low[11:3] == 9'd0));

    assert_nonprot_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault_type != 3'd0 && rsp_fault_type != 3'd4) |-> !exc_low[2]);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid),
    .rsp_wr_ok(rsp_wr_ok), .rsp_fault_type(rsp_fault_type), .exc_low(rsp_exc_code[11:2])
);

// File: tb/tb_ptw_walker.sv
// Directed bench for the page table walker with a table memory model.
module tb_ptw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlate_en = 1'b1;
    logic [63:0] ctl_primary = '0, ctl_secondary = '0, ctl_home = '0;
    logic [63:0] prefix_base = 64'h4_0000;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_mode = 2'b00;
    logic        req_ready, mem_req, mem_rsp_valid = 1'b0;
    logic [63:0] mem_rd_addr, mem_rsp_data = '0;
    logic        rsp_valid, rsp_wr_ok;
    logic [63:0] rsp_raddr, rsp_exc_code;
    logic [2:0]  rsp_fault_type;

    int n_chk = 0, n_bad = 0, rd_cnt = 0, rd_total = 0;
    logic busy_ready;
    logic [63:0] r_raddr, r_exc;
    logic        r_wrok;
    logic [2:0]  r_ft;
    logic [63:0] tmem [bit [63:0]];

    ptw_walker dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: answer each pending read after a varying delay
    initial forever begin
        @(negedge clk);
        if (mem_req) begin
            repeat (rd_total % 3) @(negedge clk);
            mem_rsp_data  = tmem.exists(mem_rd_addr) ? tmem[mem_rd_addr] : 64'd0;
            mem_rsp_valid = 1'b1;
            rd_cnt++;
            rd_total++;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] org(input logic [63:0] base, input int lv);
        return base + 64'h1_0000 * lv;
    endfunction

    // R4 offsets per table level
    function automatic logic [63:0] ofs(input int lv, input logic [63:0] va);
        case (lv)
            0:       return (va >> 50) & 64'h3FF8;
            1:       return (va >> 39) & 64'h3FF8;
            2:       return (va >> 28) & 64'h3FF8;
            3:       return (va >> 17) & 64'h3FF8;
            default: return (va >> 9)  & 64'h7F8;
        endcase
    endfunction

    function automatic logic [63:0] ea(input logic [63:0] base, input int lv, input logic [63:0] va);
        return org(base, lv) + ofs(lv, va);
    endfunction

    // build a walk from level 'start' (0 region-first .. 3 segment)
    task automatic build(input logic [63:0] base, input int start, input logic [63:0] va,
                         input logic [63:0] frame, input logic ro, output logic [63:0] ce);
        for (int lv = start; lv < 4; lv++)
            tmem[ea(base, lv, va)] = (lv < 3) ? (org(base, lv + 1) | (64'(3 - (lv + 1)) << 2))
                                              : org(base, 4);
        tmem[ea(base, 4, va)] = frame | (64'(ro) << 9);
        ce = org(base, start) | (64'(3 - start) << 2);
    endtask

    task automatic do_req(input logic [63:0] va, input logic wr, input logic [1:0] mode);
        int cyc = 0;
        rd_cnt = 0;
        busy_ready = 1'b0;
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_mode = mode; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && cyc < 500) begin
            if (req_ready) busy_ready = 1'b1;
            @(negedge clk);
            cyc++;
        end
        if (req_ready) busy_ready = 1'b1;
        chk("R11 response arrives", 64'(rsp_valid), 64'd1);
        chk("R11 not ready while busy", 64'(busy_ready), 64'd0);
        r_raddr = rsp_raddr; r_exc = rsp_exc_code; r_wrok = rsp_wr_ok; r_ft = rsp_fault_type;
    endtask

    localparam logic [63:0] VA_A = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] VA_B = 64'h0000_0000_7FFF_F123;
    localparam logic [63:0] VA_C = 64'h0000_03FF_1234_5678;

    task automatic t_reset();
        chk("reset req_ready", 64'(req_ready), 64'd1);
        chk("reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("reset mem_req", 64'(mem_req), 64'd0);
    endtask

    task automatic t_passthrough();
        xlate_en = 1'b0;
        do_req(64'h1_2345_6789, 1'b1, 2'b00);
        chk("R2 pass addr", r_raddr, 64'h1_2345_6789);
        chk("R2 pass wr_ok", 64'(r_wrok), 64'd1);
        chk("R2 pass no fault", 64'(r_ft), 64'd0);
        chk("R2 no reads", 64'(rd_cnt), 64'd0);
        do_req(64'h1F00, 1'b0, 2'b11);
        chk("R10 pass low prefixed", r_raddr, 64'h4_1F00);
        do_req(64'h2000, 1'b0, 2'b11);
        chk("R10 pass boundary unmoved", r_raddr, 64'h2000);
        xlate_en = 1'b1;
    endtask

    task automatic t_mode_select();
        logic [63:0] ce;
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b0, ce); ctl_primary = ce;
        build(64'h20_0000, 3, VA_B, 64'h7_7777_7000, 1'b0, ce); ctl_secondary = ce;
        build(64'h30_0000, 2, VA_C, 64'h9_8765_4000, 1'b0, ce); ctl_home = ce;
        do_req(VA_A, 1'b0, 2'b00);
        chk("R1 R4 R7 primary region-first addr", r_raddr, 64'h42_1234_5DEF);
        chk("R7 primary wr_ok", 64'(r_wrok), 64'd1);
        chk("R11 five reads", 64'(rd_cnt), 64'd5);
        do_req(VA_A, 1'b0, 2'b01);
        chk("R1 mode 01 uses primary", r_raddr, 64'h42_1234_5DEF);
        do_req(VA_B, 1'b0, 2'b10);
        chk("R1 R4 secondary segment addr", r_raddr, 64'h7_7777_7123);
        chk("R11 two reads", 64'(rd_cnt), 64'd2);
        do_req(VA_C, 1'b0, 2'b11);
        chk("R1 R4 home region-third addr", r_raddr, 64'h9_8765_4678);
        chk("R11 three reads", 64'(rd_cnt), 64'd3);
    endtask

    task automatic t_range();
        tmem.delete();
        ctl_primary   = 64'h10_0000 | (64'd2 << 2);
        ctl_secondary = 64'h10_0000 | (64'd1 << 2);
        ctl_home      = 64'h10_0000;
        do_req(64'h0080_0000_0000_0ABC, 1'b0, 2'b00);
        chk("R3 region-second misfit type", 64'(r_ft), 64'd1);
        chk("R9 region-second code", r_exc, 64'h0080_0000_0000_0000);
        chk("R3 no reads", 64'(rd_cnt), 64'd0);
        do_req(64'h0000_0400_0000_1000, 1'b0, 2'b10);
        chk("R3 region-third misfit type", 64'(r_ft), 64'd1);
        chk("R9 region-third code", r_exc, 64'h0000_0400_0000_1002);
        do_req(64'h8000_0FFF, 1'b0, 2'b11);
        chk("R3 segment misfit type", 64'(r_ft), 64'd1);
        chk("R9 segment code", r_exc, 64'h8000_0003);
    endtask

    task automatic t_invalid();
        logic [63:0] ce;
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b0, ce); ctl_primary = ce;
        tmem[ea(64'h10_0000, 1, VA_A)] |= 64'h20;
        do_req(VA_A, 1'b0, 2'b00);
        chk("R5 invalid region entry", 64'(r_ft), 64'd2);
        chk("R5 stops at second read", 64'(rd_cnt), 64'd2);
        chk("R9 invalid region code", r_exc, 64'h0123_4567_89AB_C000);
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b0, ce);
        tmem[ea(64'h10_0000, 4, VA_A)] |= 64'h400;
        do_req(VA_A, 1'b0, 2'b00);
        chk("R5 invalid page entry", 64'(r_ft), 64'd3);
        chk("R5 page fault no write", 64'(r_wrok), 64'd0);
        tmem.delete();
        build(64'h20_0000, 3, VA_B, 64'h7_7777_7000, 1'b0, ce); ctl_secondary = ce;
        tmem[ea(64'h20_0000, 3, VA_B)] |= 64'h20;
        do_req(VA_B, 1'b0, 2'b10);
        chk("R5 invalid segment entry", 64'(r_ft), 64'd2);
        chk("R9 invalid segment code", r_exc, 64'h7FFF_F002);
    endtask

    task automatic t_type();
        logic [63:0] ce;
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b0, ce); ctl_primary = ce;
        tmem[ea(64'h10_0000, 0, VA_A)] &= ~64'hC;
        do_req(VA_A, 1'b0, 2'b00);
        chk("R6 region type mismatch", 64'(r_ft), 64'd1);
        chk("R6 stops at first read", 64'(rd_cnt), 64'd1);
    endtask

    task automatic t_perm();
        logic [63:0] ce;
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b1, ce);
        ctl_primary = ce; ctl_secondary = ce;
        do_req(VA_A, 1'b0, 2'b00);
        chk("R7 read-only read addr", r_raddr, 64'h42_1234_5DEF);
        chk("R7 read-only wr_ok", 64'(r_wrok), 64'd0);
        do_req(VA_A, 1'b1, 2'b10);
        chk("R8 read-only write fault", 64'(r_ft), 64'd4);
        chk("R9 protection code", r_exc, 64'h0123_4567_89AB_C006);
        tmem.delete();
        build(64'h10_0000, 0, VA_A, 64'h42_1234_5000, 1'b0, ce);
        do_req(VA_A, 1'b1, 2'b00);
        chk("R8 writable write no fault", 64'(r_ft), 64'd0);
        chk("R7 writable wr_ok", 64'(r_wrok), 64'd1);
    endtask

    task automatic t_prefix();
        logic [63:0] ce;
        logic [63:0] va = 64'h1234_5234;
        tmem.delete();
        build(64'h10_0000, 3, va, 64'h1000, 1'b0, ce); ctl_primary = ce;
        do_req(va, 1'b0, 2'b00);
        chk("R10 low frame prefixed", r_raddr, 64'h4_1234);
        tmem.delete();
        build(64'h10_0000, 3, va, 64'h2000, 1'b0, ce);
        do_req(va, 1'b0, 2'b00);
        chk("R10 frame at limit unmoved", r_raddr, 64'h2234);
        tmem.delete();
        build(64'h10_0000, 3, va, 64'h1000, 1'b1, ce);
        do_req(va, 1'b0, 2'b00);
        chk("R10 read-only low frame prefixed", r_raddr, 64'h4_1234);
        chk("R7 read-only low frame wr_ok", 64'(r_wrok), 64'd0);
        do_req(va, 1'b1, 2'b00);
        chk("R8 protection wins over prefix", 64'(r_ft), 64'd4);
        chk("R9 protection low code", r_exc, 64'h1234_5004);
        chk("R8 fault wr_ok low", 64'(r_wrok), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_passthrough();
        t_mode_select();
        t_range();
        t_invalid();
        t_type();
        t_perm();
        t_prefix();
        summary();
        $finish;
    end
endmodule